// File: doc/BRIEF.md
# Matrix Key Burst Drive Sequencer

This block runs one acquisition of a single key in a 4 by 8 capacitive key matrix. A start pulse latches the key index, the burst length and the key's offset code. The block then drives the chosen drive line with a burst of pulses. Around each pulse it opens the chosen gate line in quadrature: the gate opens before the drive edge rises and closes after it. Between pulses a ground-discharge switch is enabled. A guard band with both switches off separates every gate window from every discharge window.

The block also provides a trimmed copy of the gate. This copy closes a fixed number of cycles after each drive rising edge, which limits the charge picked up from a water film on the panel. When the burst ends, the drive pins are reused to present the offset code to an external ladder DAC. After a settling interval the block issues a one-cycle sample strobe, then a one-cycle completion pulse, and returns to idle. All durations are counted in clock cycles and set by parameters.

Top module: `mkb_burst_seq`

## Requirements
- R1: An accepted start with burst length n produces exactly n rising edges on drive line `key_idx[1:0]`, each held high for LAG+GUARD cycles.
- R2: Gate line `key_idx[4:2]` rises exactly LEAD cycles before each drive rising edge and stays high through the first LAG cycles of the drive pulse, giving LEAD+LAG gate cycles per pulse.
- R3: From the end of the burst until the sample strobe, `x_bus` carries the latched offset code and the gate bus is all low.
- R4: `sample_stb` is high for exactly one cycle. With the first cycle after the start edge counted as 0, that cycle is n*(LEAD+LAG+GUARD+DUMP)+(n-1)*GUARD+SETTLE for n≥1. The strobe is never high while the gate or the discharge switch is active.
- R5: The trimmed gate is never high while its gate line is low. It falls SHORT cycles after each drive rising edge, giving LEAD+SHORT cycles per pulse.
- R6: `dump_en` is high for DUMP cycles after each pulse. It is never high together with any gate line. At least GUARD idle cycles separate a gate fall from the next discharge rise, and a discharge fall from the next gate rise.
- R7: `acq_done` is high for exactly one cycle, the cycle after the strobe. The outputs are all low on the cycle after that.
- R8: During the burst, no drive line other than the selected one and no gate line other than the selected one is ever high.
- R9: A burst length of 0 skips the burst. The offset code appears at cycle 0 and the strobe follows at cycle SETTLE.
- R10: A start pulse that arrives while an acquisition is running is ignored. The running key, offset and timing are unchanged, and no second acquisition follows.
- R11: After reset, with no start applied, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin acquisition (accepted only when idle) |
| key_idx | input | KW (5) | Key index: low bits pick the drive line, high bits pick the gate line |
| burst_len | input | CW | Number of pulses in the burst |
| offset_code | input | NX (4) | Ladder DAC offset for this key |
| x_bus | output | NX | Drive lines during the burst, offset code afterwards |
| y_bus | output | NY | Gate lines |
| y_short | output | NY | Trimmed gate lines |
| dump_en | output | 1 | Ground-discharge switch enable |
| sample_stb | output | 1 | One-cycle sample strobe |
| acq_done | output | 1 | One-cycle acquisition complete |

## Verification
The bench builds the block with LEAD=2, LAG=3, GUARD=1, DUMP=2, SETTLE=4 and SHORT=2. With these values a five-pulse burst lasts about forty cycles, so every phase boundary can be checked cycle by cycle. GUARD=1 makes the non-overlap margin as tight as it can be, so any off-by-one in the discharge or gate timing breaks it. SHORT=2 is less than LAG but equal to DUMP+GUARD−1, so the trimmed gate is checked close to both of its limits. Keys at both corners of the matrix, a zero-length burst and a start pulse arriving mid-burst are all covered.

// File: rtl/mkb_pkg.sv
package mkb_pkg;
   typedef enum logic [3:0] {
      PH_IDLE,
      PH_LEAD,
      PH_LAG,
      PH_GUARD,
      PH_DUMP,
      PH_SPACE,
      PH_SETTLE,
      PH_SAMPLE,
      PH_DONE
   } mkb_phase_e;
endpackage

// File: rtl/mkb_phase_ctrl.sv
module mkb_phase_ctrl
   import mkb_pkg::*;
#(
   parameter int CW     = 8,
   parameter int LEAD   = 4,
   parameter int LAG    = 6,
   parameter int GUARD  = 2,
   parameter int DUMP   = 8,
   parameter int SETTLE = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] burst_len,
   output mkb_phase_e    phase
);
   localparam int M1   = (LEAD > LAG) ? LEAD : LAG;
   localparam int M2   = (GUARD > DUMP) ? GUARD : DUMP;
   localparam int M3   = (M1 > M2) ? M1 : M2;
   localparam int MAXT = (M3 > SETTLE) ? M3 : SETTLE;
   localparam int TW   = $clog2(MAXT + 1);

   logic [TW-1:0] tmr;
   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         tmr   <= '0;
         left  <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  if (burst_len == '0) begin
                     phase <= PH_SETTLE;
                     tmr   <= TW'(SETTLE - 1);
                  end else begin
                     phase <= PH_LEAD;
                     tmr   <= TW'(LEAD - 1);
                     left  <= burst_len;
                  end
               end
            end
            PH_SAMPLE: phase <= PH_DONE;
            PH_DONE:   phase <= PH_IDLE;
            default: begin
               if (tmr != '0) begin
                  tmr <= tmr - TW'(1);
               end else begin
                  case (phase)
                     PH_LEAD: begin
                        phase <= PH_LAG;
                        tmr   <= TW'(LAG - 1);
                     end
                     PH_LAG: begin
                        phase <= PH_GUARD;
                        tmr   <= TW'(GUARD - 1);
                     end
                     PH_GUARD: begin
                        phase <= PH_DUMP;
                        tmr   <= TW'(DUMP - 1);
                        left  <= left - CW'(1);
                     end
                     PH_DUMP: begin
                        if (left == '0) begin
                           phase <= PH_SETTLE;
                           tmr   <= TW'(SETTLE - 1);
                        end else begin
                           phase <= PH_SPACE;
                           tmr   <= TW'(GUARD - 1);
                        end
                     end
                     PH_SPACE: begin
                        phase <= PH_LEAD;
                        tmr   <= TW'(LEAD - 1);
                     end
                     PH_SETTLE: phase <= PH_SAMPLE;
                     default:   phase <= PH_IDLE;
                  endcase
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/mkb_line_decode.sv
module mkb_line_decode #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [W-1:0] sel,
   input  logic         en,
   output logic [N-1:0] lines
);
   for (genvar i = 0; i < N; i++) begin : g_line
      assign lines[i] = en && (sel == W'(i));
   end
endmodule

// File: rtl/mkb_gate_trim.sv
module mkb_gate_trim #(
   parameter int NY     = 8,
   parameter bit ENABLE = 1'b1,
   parameter int SHORT  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          x_active,
   input  logic [NY-1:0] y_in,
   output logic [NY-1:0] y_out
);
   if (ENABLE) begin : g_trim
      logic [SHORT-1:0] dly;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dly <= '0;
         end else begin
            dly[0] <= x_active;
            for (int i = 1; i < SHORT; i++) dly[i] <= dly[i-1];
         end
      end
      assign y_out = y_in & {NY{~dly[SHORT-1]}};
   end else begin : g_pass
      assign y_out = y_in;
   end
endmodule

// File: rtl/mkb_burst_seq.sv
module mkb_burst_seq
   import mkb_pkg::*;
#(
   parameter int NX        = 4,
   parameter int NY        = 8,
   parameter int CW        = 8,
   parameter int LEAD      = 4,
   parameter int LAG       = 6,
   parameter int GUARD     = 2,
   parameter int DUMP      = 8,
   parameter int SETTLE    = 32,
   parameter bit USE_SHORT = 1'b1,
   parameter int SHORT     = 3,
   localparam int XW       = $clog2(NX),
   localparam int YW       = $clog2(NY),
   localparam int KW       = XW + YW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [KW-1:0] key_idx,
   input  logic [CW-1:0] burst_len,
   input  logic [NX-1:0] offset_code,
   output logic [NX-1:0] x_bus,
   output logic [NY-1:0] y_bus,
   output logic [NY-1:0] y_short,
   output logic          dump_en,
   output logic          sample_stb,
   output logic          acq_done
);
   if ((1 << XW) != NX || (1 << YW) != NY || NX < 2 || NY < 2) begin : g_bad_dim
      $error("line counts must be powers of two, at least 2");
   end
   if (LEAD < 1 || LAG < 1 || GUARD < 1 || DUMP < 1 || SETTLE < 1) begin : g_bad_time
      $error("every phase needs at least one cycle");
   end
   if (USE_SHORT && (SHORT < 1 || SHORT > LAG || SHORT > DUMP + GUARD)) begin : g_bad_short
      $error("SHORT must lie in 1..LAG and not exceed DUMP+GUARD");
   end

   mkb_phase_e    phase;
   logic [KW-1:0] key_q;
   logic [NX-1:0] offs_q;
   logic          x_on, y_on, off_on;
   logic [NX-1:0] x_drive_lines;

   mkb_phase_ctrl #(
      .CW(CW), .LEAD(LEAD), .LAG(LAG), .GUARD(GUARD), .DUMP(DUMP), .SETTLE(SETTLE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len), .phase(phase)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         offs_q <= '0;
      end else if (phase == PH_IDLE && start) begin
         key_q  <= key_idx;
         offs_q <= offset_code;
      end
   end

   assign x_on   = (phase == PH_LAG) || (phase == PH_GUARD);
   assign y_on   = (phase == PH_LEAD) || (phase == PH_LAG);
   assign off_on = (phase == PH_SETTLE) || (phase == PH_SAMPLE);

   mkb_line_decode #(.N(NX), .W(XW)) u_xdec (
      .sel(key_q[XW-1:0]), .en(x_on), .lines(x_drive_lines)
   );
   mkb_line_decode #(.N(NY), .W(YW)) u_ydec (
      .sel(key_q[KW-1:XW]), .en(y_on), .lines(y_bus)
   );
   mkb_gate_trim #(.NY(NY), .ENABLE(USE_SHORT), .SHORT(SHORT)) u_trim (
      .clk(clk), .rst_n(rst_n), .x_active(x_on), .y_in(y_bus), .y_out(y_short)
   );

   assign x_bus      = off_on ? offs_q : x_drive_lines;
   assign dump_en    = (phase == PH_DUMP);
   assign sample_stb = (phase == PH_SAMPLE);
   assign acq_done   = (phase == PH_DONE);
endmodule

// File: rtl/mkb_burst_seq_chk.sv
module mkb_burst_seq_chk #(
   parameter int NX = 4,
   parameter int NY = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NX-1:0] x_drv,
   input logic [NY-1:0] y_bus,
   input logic [NY-1:0] y_short,
   input logic          dump_en,
   input logic          sample_stb,
   input logic          acq_done
);
   AST_Y_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(y_bus)); // R8
   AST_X_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(x_drv)); // R8
   AST_NO_Y_DUMP: assert property (@(posedge clk) disable iff (!rst_n) !((|y_bus) && dump_en)); // R6
   AST_DUMP_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(dump_en) |-> $past(y_bus) == '0); // R6
   AST_X_RISE_GATED: assert property (@(posedge clk) disable iff (!rst_n) $rose(|x_drv) |-> (|y_bus) && $past(|y_bus)); // R2
   AST_STB_QUIET: assert property (@(posedge clk) disable iff (!rst_n) sample_stb |-> (y_bus == '0) && !dump_en); // R4
   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) sample_stb |=> acq_done); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) acq_done |=> !acq_done); // R7
   AST_TRIM_INSIDE: assert property (@(posedge clk) disable iff (!rst_n) (y_short & ~y_bus) == '0); // R5
endmodule

bind mkb_burst_seq mkb_burst_seq_chk #(.NX(NX), .NY(NY)) u_chk (
   .clk(clk), .rst_n(rst_n), .x_drv(x_drive_lines), .y_bus(y_bus), .y_short(y_short),
   .dump_en(dump_en), .sample_stb(sample_stb), .acq_done(acq_done)
);

// File: tb/mkb_burst_seq_test.sv
`timescale 1ns/1ps
module mkb_burst_seq_test;
   localparam int NX = 4, NY = 8, CW = 4;
   localparam int LEAD = 2, LAG = 3, GUARD = 1, DUMP = 2, SETTLE = 4, SHORT = 2;
   localparam int P = LEAD + LAG + GUARD + DUMP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [4:0] key_i = '0;
   logic [CW-1:0] len_i = '0;
   logic [NX-1:0] off_i = '0;
   logic [NX-1:0] x_bus;
   logic [NY-1:0] y_bus, y_short;
   logic dump_en, sample_stb, acq_done;

   int total = 0;
   int fails = 0;

   always #2 clk = ~clk;

   mkb_burst_seq #(
      .NX(NX), .NY(NY), .CW(CW), .LEAD(LEAD), .LAG(LAG), .GUARD(GUARD),
      .DUMP(DUMP), .SETTLE(SETTLE), .USE_SHORT(1'b1), .SHORT(SHORT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .key_idx(key_i), .burst_len(len_i),
      .offset_code(off_i), .x_bus(x_bus), .y_bus(y_bus), .y_short(y_short),
      .dump_en(dump_en), .sample_stb(sample_stb), .acq_done(acq_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // One acquisition, every output checked cycle by cycle against the timeline.
   task automatic acquire(input logic [4:0] k, input int n, input logic [NX-1:0] o,
                          input bit busy_start);
      logic [NX-1:0] ex;
      logic [NY-1:0] ey;
      int off_start, stb_idx, last;
      int xr = 0, xc = 0, yc = 0, ysc = 0, dc = 0;
      int stray = 0, quad = 0, gap = 0, offbad = 0, stb_bad = 0, done_bad = 0, tail = 0;
      int last_yfall = -100, last_dfall = -100, yrise = -100;
      bit px = 0, py = 0, pd = 0, seen_d = 0;
      ex = NX'(1) << k[1:0];
      ey = NY'(1) << k[4:2];
      off_start = (n == 0) ? 0 : n * P + (n - 1) * GUARD;
      stb_idx = off_start + SETTLE;
      last = stb_idx + 2;
      @(negedge clk);
      key_i = k; len_i = CW'(n); off_i = o; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int idx = 0; idx <= last; idx++) begin
         bit cx, cy, cd;
         cx = (x_bus & ex) != '0;
         cy = (y_bus & ey) != '0;
         cd = dump_en;
         if (idx < off_start) begin
            if ((x_bus & ~ex) != '0 || (y_bus & ~ey) != '0) stray++;
            if (cx) xc++;
            if (cy) yc++;
            if ((y_short & ey) != '0) ysc++;
            if (cd) dc++;
            if (cy && !py) begin
               yrise = idx;
               if (seen_d && idx - last_dfall < GUARD) gap++;
            end
            if (!cy && py) last_yfall = idx;
            if (cd && !pd && idx - last_yfall < GUARD) gap++;
            if (!cd && pd) last_dfall = idx;
            if (cd) seen_d = 1;
            if (cd && cy) gap++;
            if (cx && !px) begin
               xr++;
               if (idx - yrise != LEAD || !py || !cy) quad++;
            end
            if (sample_stb) stb_bad++;
         end else if (idx <= stb_idx) begin
            if (x_bus != o || y_bus != '0 || dump_en) offbad++;
            if (sample_stb != (idx == stb_idx)) stb_bad++;
            if (acq_done) done_bad++;
         end else if (idx == stb_idx + 1) begin
            if (!acq_done || sample_stb) done_bad++;
         end else begin
            if (acq_done || sample_stb || x_bus != '0 || y_bus != '0 || dump_en) tail++;
         end
         px = cx; py = cy; pd = cd;
         if (busy_start && idx == 3) begin
            start = 1'b1; key_i = ~k; off_i = ~o; len_i = '1;
         end else if (busy_start && idx == 4) begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      chk(xr == n, "R1 drive rising edges", xr, n);
      chk(xc == n * (LAG + GUARD), "R1 drive high cycles", xc, n * (LAG + GUARD));
      chk(yc == n * (LEAD + LAG) && quad == 0, "R2 gate quadrature", yc, n * (LEAD + LAG));
      chk(offbad == 0, "R3 offset on drive pins", offbad, 0);
      chk(stb_bad == 0, "R4 strobe timing", stb_bad, 0);
      chk(ysc == n * (LEAD + SHORT), "R5 trimmed gate cycles", ysc, n * (LEAD + SHORT));
      chk(dc == n * DUMP && gap == 0, "R6 discharge and guard", dc + 100 * gap, n * DUMP);
      chk(done_bad == 0 && tail == 0, "R7 done then idle", done_bad + tail, 0);
      chk(stray == 0, "R8 unselected lines low", stray, 0);
   endtask

   task automatic t_reset();
      chk(x_bus == '0 && y_bus == '0 && y_short == '0 && !dump_en && !sample_stb && !acq_done,
          "R11 reset outputs", int'(x_bus) + int'(y_bus), 0);
   endtask

   task automatic t_basic();
      acquire(5'd0, 3, 4'hA, 1'b0);
   endtask

   task automatic t_corner_key();
      acquire(5'd31, 1, 4'h5, 1'b0);
   endtask

   task automatic t_zero_len();  // R9
      acquire(5'd13, 0, 4'hF, 1'b0);
   endtask

   task automatic t_busy_start(); // R10: late start must change nothing
      acquire(5'd9, 5, 4'h3, 1'b1);
      repeat (3) begin
         @(negedge clk);
         chk(x_bus == '0 && y_bus == '0 && !sample_stb, "R10 no second acquisition",
             int'(x_bus), 0);
      end
   endtask

   task automatic t_mid_key();  // R9 also confirmed by a full burst after the skip
      acquire(5'd22, 2, 4'h6, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_corner_key();
      t_zero_len();
      t_mid_key();
      t_busy_start();
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule